// File: doc/BRIEF.md
# Peripheral Interrupt Collector with Keyed Soft Reset

This block sits next to a serial-peripheral master and shares its register port. It watches seven event lines coming from the serial core. It remembers each event in a sticky status bit and combines the pending bits into a single level-sensitive interrupt request. Software controls the request with a per-event mask and one master gate bit. It acknowledges events by writing the status value it read back to the status register.

The same port also holds a reset register. When the exact key value is written there, the block raises a one-cycle reset pulse for the rest of the peripheral, such as the control register and the FIFOs. In the same cycle it returns its own interrupt state to the power-up values. A write of any other value to that offset does nothing.

Top module: `irq_rst_unit`

## Requirements
- R1: After the reset input is released, the gate bit, the status bits and the mask bits all read 0, `irqOut` is 0 and `softRstOut` is 0.
- R2: A 0-to-1 change on `evtIn[i]`, sampled at a clock edge, sets status bit i at that edge. A line held high sets its bit only once. Bit meanings: 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit half empty.
- R3: Writing to offset 0x20 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. Reading 0x20 returns the status in bits 6:0.
- R4: If a rising event and a clearing write hit the same status bit at the same edge, the bit remains set.
- R5: Offset 0x28 holds the per-event mask in bits 6:0. Writes store bits 6:0, and upper bits read as 0.
- R6: Offset 0x1C holds the gate in bit 31. All other bits are discarded on write and read as 0.
- R7: `irqOut` is 1 exactly when the gate bit is 1 and at least one status bit is 1 with its mask bit also 1. It follows the register contents within the cycle after the edge that changed them.
- R8: Writing exactly 0x0000000A to offset 0x40 drives `softRstOut` high for the one cycle after that edge. At the same edge it clears the gate, the status and the mask. This soft reset overrides an event rising at the same edge.
- R9: Writing any other value to offset 0x40 leaves `softRstOut` low and leaves every register unchanged.
- R10: Reads of offset 0x40 and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, one write per cycle it is high |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| evtIn | input | 7 | Event lines from the serial core |
| irqOut | output | 1 | Level interrupt request |
| softRstOut | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a new rising event and a software clear of that same status bit. The second pair is a new rising event and a keyed soft reset. The bench provokes each pair by raising `evtIn` in the same cycle as the register write, with the line held low for at least one edge beforehand. It then reads the status back: for the clear case it expects the event bit to survive while other bits in the written mask are cleared, and for the reset case it expects the whole status to be zero.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_GATE,
    SEL_STATUS,
    SEL_MASK
  } readSel_t;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic     wrGate;
    logic     wrStatus;
    logic     wrMask;
    logic     doReset;
    readSel_t rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_rst_ctrl.sv
module irq_rst_ctrl
  import irq_rst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] GATE_OFF = 8'h1C,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h20,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h28,
  parameter logic [ADDR_W-1:0] RESET_OFF = 8'h40,
  parameter logic [DATA_W-1:0] RESET_KEY = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output ctrlStrobe_t       stb,
  output logic              softRstOut
);

  logic keyHit;
  logic softRstQ;

  assign keyHit = busWrEn && (busAddr == RESET_OFF) && (busWrData == RESET_KEY);

  always_comb begin
    stb          = '0;
    stb.rdSel    = SEL_NONE;
    stb.wrGate   = busWrEn && (busAddr == GATE_OFF);
    stb.wrStatus = busWrEn && (busAddr == STATUS_OFF);
    stb.wrMask   = busWrEn && (busAddr == MASK_OFF);
    stb.doReset  = keyHit;
    if (busAddr == GATE_OFF)        stb.rdSel = SEL_GATE;
    else if (busAddr == STATUS_OFF) stb.rdSel = SEL_STATUS;
    else if (busAddr == MASK_OFF)   stb.rdSel = SEL_MASK;
  end

  // Pulse to the peripheral is registered so it is glitch free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softRstQ <= 1'b0;
    else       softRstQ <= keyHit;
  end

  assign softRstOut = softRstQ;

  // R9: a non-key write to the reset offset never produces a pulse
  p_bad_key_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == RESET_OFF && busWrData != RESET_KEY) |=> !softRstOut);

  // R8: every pulse is preceded by an exact key write
  p_pulse_has_key_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRstOut) |-> $past(busWrEn && busAddr == RESET_OFF && busWrData == RESET_KEY));

endmodule

// File: rtl/irq_rst_regs.sv
module irq_rst_regs
  import irq_rst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_EVT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int GATE_BIT = DATA_W - 1;
  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] evtPrev;
  logic [NUM_EVT-1:0] rise;
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_EVT-1:0] maskQ;
  logic               gateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= '0;
    else       evtPrev <= evtIn;
  end

  assign rise = evtIn & ~evtPrev;

  // One sticky cell per event; a fresh event outranks a clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_status
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               statusQ[i] <= 1'b0;
      else if (stb.doReset)    statusQ[i] <= 1'b0;
      else if (rise[i])        statusQ[i] <= 1'b1;
      else if (stb.wrStatus && wrData[i]) statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      gateQ <= 1'b0;
    end else if (stb.doReset) begin
      maskQ <= '0;
      gateQ <= 1'b0;
    end else begin
      if (stb.wrMask) maskQ <= wrData[NUM_EVT-1:0];
      if (stb.wrGate) gateQ <= wrData[GATE_BIT];
    end
  end

  assign irqOut = gateQ && |(statusQ & maskQ);

  always_comb begin
    unique case (stb.rdSel)
      SEL_GATE:   rdData = {gateQ, {(DATA_W-1){1'b0}}};
      SEL_STATUS: rdData = {{PAD_W{1'b0}}, statusQ};
      SEL_MASK:   rdData = {{PAD_W{1'b0}}, maskQ};
      default:    rdData = '0;
    endcase
  end

  // R2: a rising event always lands in status unless a soft reset hits
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|rise && !stb.doReset) |=> ((statusQ & $past(rise)) == $past(rise)));

  // R3: written ones clear, except where an event rose at that edge
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStatus && !stb.doReset) |=> ((statusQ & $past(wrData[NUM_EVT-1:0] & ~rise)) == '0));

  // R3: without a clearing write nothing already set is lost
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrStatus && !stb.doReset) |=> (($past(statusQ) & ~statusQ) == '0));

  // R8: soft reset leaves the interrupt state empty and the request low
  p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.doReset |=> (statusQ == '0 && maskQ == '0 && !gateQ && !irqOut));

endmodule

// File: rtl/irq_rst_unit.sv
module irq_rst_unit
  import irq_rst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic               irqOut,
  output logic               softRstOut
);

  ctrlStrobe_t stb;

  irq_rst_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busWrData(busWrData),
    .stb(stb),
    .softRstOut(softRstOut)
  );

  irq_rst_regs #(
    .DATA_W(DATA_W),
    .NUM_EVT(NUM_EVT)
  ) regs_i (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .wrData(busWrData),
    .evtIn(evtIn),
    .rdData(busRdData),
    .irqOut(irqOut)
  );

endmodule

// File: tb/irq_rst_unit_tb_top.sv
module irq_rst_unit_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] A_GATE = 8'h1C;
  localparam logic [7:0] A_STS = 8'h20;
  localparam logic [7:0] A_MASK = 8'h28;
  localparam logic [7:0] A_RST = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [6:0]  evtIn = '0;
  logic        irqOut;
  logic        softRstOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] expData;
    logic        expIrq;
    logic        expRst;
    string       tag;
  } item_t;

  item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_rst_unit dut_i (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .evtIn(evtIn),
    .irqOut(irqOut),
    .softRstOut(softRstOut)
  );

  // Monitor: compares outputs mid-cycle against the queued expectation
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      nChecks++;
      if (busRdData !== it.expData || irqOut !== it.expIrq || softRstOut !== it.expRst) begin
        nFails++;
        $display("FAIL %s: actual rd=%h irq=%b rst=%b expected rd=%h irq=%b rst=%b",
                 it.tag, busRdData, irqOut, softRstOut, it.expData, it.expIrq, it.expRst);
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] d,
                           input logic irq, input logic rst, input string tag);
    item_t it;
    busAddr = a;
    busWrEn = 1'b0;
    it.expData = d; it.expIrq = irq; it.expRst = rst; it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] m);
    evtIn = m;
    @(posedge clk); #1;
    evtIn = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    expect_rd(A_GATE, 32'h0, 0, 0, "R1 gate after reset");
    expect_rd(A_STS,  32'h0, 0, 0, "R1 status after reset");
    expect_rd(A_MASK, 32'h0, 0, 0, "R1 mask after reset");
    expect_rd(A_RST,  32'h0, 0, 0, "R10 reset offset reads zero");

    pulse(7'h04);
    expect_rd(A_STS, 32'h04, 0, 0, "R2 tx-empty event latched");
    expect_rd(8'h24, 32'h0, 0, 0, "R10 unmapped offset reads zero");

    wr(A_MASK, 32'hFFFF_FFFF);
    expect_rd(A_MASK, 32'h7F, 0, 0, "R5 mask keeps low bits, R7 gate off");
    wr(A_GATE, 32'h7FFF_FFFF);
    expect_rd(A_GATE, 32'h0, 0, 0, "R6 only bit31 stored");
    wr(A_GATE, 32'h8000_0000);
    expect_rd(A_GATE, 32'h8000_0000, 1, 0, "R7 gate on raises request");
    wr(A_MASK, 32'h03);
    expect_rd(A_MASK, 32'h03, 0, 0, "R7 masked pending bit keeps request low");
    wr(A_MASK, 32'h04);
    expect_rd(A_STS, 32'h04, 1, 0, "R7 unmasked pending bit");

    wr(A_STS, 32'h04);
    expect_rd(A_STS, 32'h0, 0, 0, "R3 write-back clears");
    pulse(7'h41);
    wr(A_STS, 32'h0);
    expect_rd(A_STS, 32'h41, 0, 0, "R3 zero write has no effect");
    wr(A_STS, 32'h01);
    expect_rd(A_STS, 32'h40, 0, 0, "R3 selective clear");

    evtIn = 7'h08;
    @(posedge clk); #1;
    wr(A_STS, 32'h08);
    expect_rd(A_STS, 32'h40, 0, 0, "R2 held level does not re-set");
    evtIn = '0;

    pulse(7'h10);
    expect_rd(A_STS, 32'h50, 0, 0, "R2 rx-full latched");
    evtIn = 7'h10; busAddr = A_STS; busWrData = 32'h50; busWrEn = 1'b1;
    @(posedge clk); #1;
    evtIn = '0; busWrEn = 1'b0;
    expect_rd(A_STS, 32'h10, 0, 0, "R4 event beats clear same edge");
    wr(A_MASK, 32'h10);
    expect_rd(A_STS, 32'h10, 1, 0, "R7 request from rx-full");

    wr(A_RST, 32'h0B);
    expect_rd(A_GATE, 32'h8000_0000, 1, 0, "R9 wrong key ignored");
    wr(A_RST, 32'h10A);
    expect_rd(A_MASK, 32'h10, 1, 0, "R9 key with extra bits ignored");

    evtIn = 7'h02; busAddr = A_RST; busWrData = 32'h0A; busWrEn = 1'b1;
    @(posedge clk); #1;
    evtIn = '0; busWrEn = 1'b0;
    expect_rd(A_STS, 32'h0, 0, 1, "R8 key pulses and beats event");
    expect_rd(A_GATE, 32'h0, 0, 0, "R8 pulse one cycle, gate cleared");
    expect_rd(A_MASK, 32'h0, 0, 0, "R8 mask cleared");
    pulse(7'h20);
    expect_rd(A_STS, 32'h20, 0, 0, "R8 events latch but mask stays zero");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule